// File: doc/BRIEF.md
# Clause-22 Management Frame Master

This block produces IEEE 802.3 clause-22 management frames on a serial clock and data line pair toward a PHY. Software loads one 32-bit command word; the bit layout of that word is the bit order of the frame after the preamble. Writing the word launches the whole transaction. The block sends 32 preamble ones and then shifts the word out MSB first. On a read it releases the data line for the turnaround and the data phase. The 16 bits returned by the PHY replace the low half of the command register.

The serial clock comes from the system clock through a programmable divider. A port-enable bit in the control register must be set before a command write starts a frame. Completion shows up as a done flag in the status register. The register port is a plain write strobe with an address and a combinational read. There is no valid/ready handshake, because every transfer finishes in one cycle and never waits. The pad tri-state buffer sits outside the block and is controlled by `mdio_oe`.

Register map (`reg_addr`): 0 = control (bit 0 port enable, bits [15:8] divider value D), 1 = command, 2 = status (bit 0 done, read-only). Command word: [31:30] start code, [29:28] operation (2'b10 read, 2'b01 write), [27:23] PHY address, [22:18] register address, [17:16] turnaround, [15:0] data.

Top module: `mdio_master`

## Requirements
- R1: After reset the control and command registers read 0, the status done bit reads 1, `mdc` is 0 and `mdio_oe` is 0.
- R2: A command write with port enable set starts a frame of 64 bit times. The first 32 bits are driven ones (preamble).
- R3: Frame bits 32 to 45 are the command bits [31:18] in MSB-first order (start code, operation, PHY address, register address), driven by the master.
- R4: For any operation other than 2'b10 (read), frame bits 46 to 63 are the command bits [17:0], MSB first, all driven.
- R5: For the read operation 2'b10, `mdio_oe` is 0 for frame bits 46 to 63 (two turnaround bits plus 16 data bits).
- R6: On a read, the value of `mdio_i` at the rising `mdc` edge of each of bits 48 to 63 is shifted in, MSB first, and replaces command bits [15:0]. Bits [31:16] are kept. A write leaves the command register unchanged.
- R7: The done bit reads 0 from the cycle after the launching write until the frame ends. It reads 1 exactly 128*(D+1) clock edges after the write edge.
- R8: Each `mdc` half period lasts D+1 clock cycles, and a frame has exactly 64 rising `mdc` edges.
- R9: The master changes `mdio_o` only together with a falling `mdc` edge. The value stays stable while `mdc` is high.
- R10: A command write while a frame is in flight is ignored. The frame and the register contents continue as if it had not happened.
- R11: With port enable at 0, a command write stores the word but starts no frame. Done stays 1 and `mdio_oe` stays 0.
- R12: Outside a frame, `mdc` is held at 0 and `mdio_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management serial clock |
| mdio_o | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | Drive enable for the data pad |
| mdio_i | input | 1 | Serial data seen on the pad |

## Verification
Register writes take effect at the clock edge that samples the strobe. Read data is combinational, so the bench reads it half a cycle after a write. The done bit is due exactly 128*(D+1) edges after the launching write edge. The bench counts N-1 edges after that write edge and checks that done is still 0, then checks one edge later that done is 1. Frame bits and drive enables are captured at each rising `mdc` edge, when the data line has been stable for a full half period. The read result is checked only after done has risen.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_W    = 32;
  localparam int DATA_W   = 16;
  localparam int PRE_BITS = 32;
  localparam int FRAME_BITS = PRE_BITS + CMD_W;
  localparam int IDX_W    = $clog2(FRAME_BITS);
  // frame bit (after preamble) where the read turnaround starts
  localparam int TA_POS   = 14;
  localparam int DATA_POS = TA_POS + 2;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_CMD    = 2'd1,
    RA_STATUS = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R8
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && div != '0) |=> !tick);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  output logic             busy,
  output logic             mdc,
  output logic             rise,
  output logic [IDX_W-1:0] bit_idx
);
  logic phase_hi;

  assign rise = tick && !phase_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mdc      <= 1'b0;
      phase_hi <= 1'b0;
      bit_idx  <= '0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      mdc      <= 1'b0;
      phase_hi <= 1'b0;
      bit_idx  <= '0;
    end else if (busy && tick) begin
      if (!phase_hi) begin
        phase_hi <= 1'b1;
        mdc      <= 1'b1;
      end else begin
        phase_hi <= 1'b0;
        mdc      <= 1'b0;
        if (bit_idx == IDX_W'(FRAME_BITS - 1)) busy <= 1'b0;
        else                                   bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  // R12
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R8
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(bit_idx) == IDX_W'(FRAME_BITS - 1)) && $fell(mdc));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int DIV_LSB = 8;

  logic             port_en;
  logic [DIV_W-1:0] div_q;
  logic [CMD_W-1:0] cmd_q;
  logic             busy, tick, rise, start;
  logic [IDX_W-1:0] bit_idx;
  logic [4:0]       cmd_pos;
  logic             in_cmd, is_read, released, drive_bit;

  assign start   = reg_wr && (reg_addr == RA_CMD) && port_en && !busy;
  assign is_read = (cmd_q[29:28] == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_en <= 1'b0;
      div_q   <= '0;
    end else if (reg_wr && reg_addr == RA_CTRL) begin
      port_en <= reg_wdata[0];
      div_q   <= reg_wdata[DIV_LSB +: DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cmd_q <= '0;
    else if (reg_wr && reg_addr == RA_CMD && !busy)
      cmd_q <= reg_wdata;
    else if (busy && rise && is_read && bit_idx >= IDX_W'(PRE_BITS + DATA_POS))
      cmd_q[DATA_W-1:0] <= {cmd_q[DATA_W-2:0], mdio_i};
  end

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
  );

  mdio_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .busy(busy), .mdc(mdc), .rise(rise), .bit_idx(bit_idx)
  );

  // serial output: preamble ones, then command word MSB first
  assign in_cmd    = bit_idx[IDX_W-1];
  assign cmd_pos   = bit_idx[4:0];
  assign released  = is_read && in_cmd && (cmd_pos >= 5'(TA_POS));
  assign drive_bit = in_cmd ? cmd_q[~cmd_pos] : 1'b1;
  assign mdio_oe   = busy && !released;
  assign mdio_o    = mdio_oe ? drive_bit : 1'b1;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:   reg_rdata = {16'd0, 8'(div_q), 7'd0, port_en};
      RA_CMD:    reg_rdata = cmd_q;
      RA_STATUS: reg_rdata = {31'd0, !busy};
      default:   reg_rdata = '0;
    endcase
  end

  // R10
  busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> cmd_q[31:16] == $past(cmd_q[31:16]));

  // R9
  fall_edge_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && mdio_o != $past(mdio_o)) |-> $fell(mdc));

  // R7
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> reg_addr != RA_STATUS || reg_rdata[0] == 1'b0);

  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && !busy) |=> !mdio_oe);
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/100ps
module mdio_master_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0, errors = 0;
  int rise_cnt = 0;
  int r9_bad = 0;
  logic [63:0] cap_bit, cap_oe;
  logic        rise_val = 1'b1;
  logic        oe_seen = 1'b0;
  logic [15:0] phy_data = 16'h0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY responder and frame capture
  always @(posedge mdc) begin
    if (rise_cnt < 64) begin
      cap_bit[63 - rise_cnt] = mdio_o;
      cap_oe[63 - rise_cnt]  = mdio_oe;
    end
    rise_val = mdio_o;
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge mdc) begin
    if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = phy_data[15 - (rise_cnt - 48)];
    else                                 mdio_i = 1'b1;
  end

  always @(negedge clk) begin
    if (mdio_oe) oe_seen = 1'b1;
    if (mdc && mdio_oe && mdio_o != rise_val) r9_bad = r9_bad + 1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  function automatic logic [63:0] exp_oe(input logic [31:0] c);
    return (c[29:28] == 2'b10) ? {32'hFFFF_FFFF, 14'h3FFF, 18'h0} : {64{1'b1}};
  endfunction

  function automatic logic [31:0] exp_cmd(input logic [31:0] c, input logic [15:0] d);
    return (c[29:28] == 2'b10) ? {c[31:16], d} : c;
  endfunction

  // one full frame; optional second command write mid-frame (R10)
  task automatic run_frame(input int div, input logic [31:0] c, input logic [15:0] d,
                           input bit poke, input logic [31:0] c2);
    logic [31:0] rv;
    logic [63:0] eo;
    int n;
    n = 128 * (div + 1);
    wr_reg(2'd0, {16'd0, 8'(div), 8'h01});
    phy_data = d; rise_cnt = 0; r9_bad = 0; cap_bit = '0; cap_oe = '0;
    wr_reg(2'd1, c);
    if (poke) begin
      repeat (n / 2) @(posedge clk);
      @(negedge clk);
      reg_addr = 2'd1; reg_wdata = c2; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      repeat (n - 1 - n / 2 - 1) @(posedge clk);
    end else begin
      repeat (n - 1) @(posedge clk);
    end
    @(negedge clk);
    rd_reg(2'd2, rv);
    check("R7 done low in flight", {63'd0, rv[0]}, 64'd0);
    @(posedge clk); @(negedge clk);
    rd_reg(2'd2, rv);
    check("R7 done at 128*(D+1)", {63'd0, rv[0]}, 64'd1);
    check("R8 rising mdc edges", 64'(rise_cnt), 64'd64);
    eo = exp_oe(c);
    check("R5 drive enable pattern", cap_oe, eo);
    check("R2 preamble", cap_bit[63:32], {32'hFFFF_FFFF});
    check("R3 header bits", {50'd0, cap_bit[31:18]}, {50'd0, c[31:18]});
    if (c[29:28] != 2'b10)
      check("R4 write tail", {46'd0, cap_bit[17:0]}, {46'd0, c[17:0]});
    check("R9 stable while mdc high", 64'(r9_bad), 64'd0);
    rd_reg(2'd1, rv);
    check(poke ? "R10 busy write ignored" : "R6 command after frame", {32'd0, rv},
          {32'd0, exp_cmd(c, d)});
    check("R12 idle lines", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  initial begin
    logic [31:0] rv;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_reg(2'd0, rv); check("R1 control reset", {32'd0, rv}, 64'd0);
    rd_reg(2'd1, rv); check("R1 command reset", {32'd0, rv}, 64'd0);
    rd_reg(2'd2, rv); check("R1 done reset", {32'd0, rv}, 64'd1);
    check("R1 lines reset", {62'd0, mdc, mdio_oe}, 64'd0);

    // R11: port disabled, word stored but nothing driven
    wr_reg(2'd0, 32'h0000_0200);
    oe_seen = 1'b0; rise_cnt = 0;
    wr_reg(2'd1, 32'h6A5A_1234);
    repeat (400) @(posedge clk);
    @(negedge clk);
    rd_reg(2'd2, rv); check("R11 done stays high", {32'd0, rv}, 64'd1);
    check("R11 no drive", {62'd0, oe_seen, 1'b0}, 64'd0);
    check("R11 no mdc", 64'(rise_cnt), 64'd0);
    rd_reg(2'd1, rv); check("R11 word stored", {32'd0, rv}, 64'h6A5A_1234);

    // directed corners
    run_frame(0, {2'b01, 2'b10, 5'h1F, 5'h00, 2'b10, 16'h0000}, 16'hFFFF, 0, 0);
    run_frame(0, {2'b01, 2'b01, 5'h00, 5'h1F, 2'b10, 16'hFFFF}, 16'h0000, 0, 0);
    run_frame(3, {2'b01, 2'b10, 5'h0A, 5'h15, 2'b10, 16'h1234}, 16'h8001, 0, 0);
    run_frame(1, {2'b01, 2'b10, 5'h03, 5'h01, 2'b10, 16'h0000}, 16'hBEEF, 1,
              32'h5555_AAAA);
    run_frame(2, {2'b01, 2'b01, 5'h11, 5'h04, 2'b10, 16'hC3A5}, 16'h0000, 1,
              32'hFFFF_FFFF);

    // random frames
    for (int i = 0; i < 24; i++) begin
      logic [31:0] c;
      logic [15:0] d;
      c = $urandom;
      c[31:30] = 2'b01;
      c[29:28] = ($urandom % 2) ? 2'b10 : 2'b01;
      c[17:16] = 2'b10;
      d = 16'($urandom);
      run_frame(int'($urandom % 4), c, d, 0, 0);
    end

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule